// File: doc/BRIEF.md
# Embedded Operation Status Toggle Generator

This block produces the status byte that a flash-style memory returns on reads while an internal program or erase operation is running. It holds a single toggle flop in bit 6. While an operation is busy, every status read inverts that flop, so a host that reads twice and sees different values knows that work is still in progress. When the operation finishes, the flop freezes and the block reports that reads return array data again.

The block also handles two special cases. If the target of an operation is protected, the block stays busy and keeps toggling for a fixed number of clock cycles, then drops back to array mode without doing anything. The erase delay is long and the program delay is short. An erase can be suspended. During the suspend the flop holds. A program issued during the suspend makes the flop toggle again until that program ends, after which the block is back in suspend. Bit 5 carries a fail indicator taken straight from an input. All other bits read zero.

Top module: `tgl_status_top`

## Requirements
- R1: After reset, status_o is 8'h00 and array_mode_o is 1.
- R2: While an operation is busy, a cycle with rd_i high inverts status_o[6], and the new value is visible after that clock edge.
- R3: done_i ends an unprotected program or erase. array_mode_o returns to 1, and after that reads leave status_o[6] unchanged.
- R4: An erase started with prot_i high stays busy for exactly ERS_TMO_CYC cycles, ignores done_i, and toggles on reads. It then returns to array mode.
- R5: A program started with prot_i high stays busy for exactly PGM_TMO_CYC cycles and toggles on reads. It then returns to array mode.
- R6: susp_i during an unprotected erase enters suspend. In suspend array_mode_o stays 0 and reads do not change status_o[6]. resume_i restarts the erase, and reads toggle again.
- R7: start_pgm_i while suspended starts a program that toggles on reads. Its done_i returns the block to suspend, not to array mode.
- R8: status_o[5] equals fail_i. status_o[7] and status_o[4:0] are always 0.
- R9: Status is valid from the cycle right after the start command: array_mode_o is 0, and a read in that cycle already toggles. Start commands issued while an operation is busy are ignored.
- R10: If start_ers_i and start_pgm_i arrive together, the erase wins. susp_i has no effect during a program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Status read strobe, one per read cycle |
| start_pgm_i | input | 1 | Start program command |
| start_ers_i | input | 1 | Start erase command |
| prot_i | input | 1 | Target is protected; sampled together with a start |
| susp_i | input | 1 | Erase suspend request |
| resume_i | input | 1 | Erase resume request |
| done_i | input | 1 | Internal algorithm finished |
| fail_i | input | 1 | Timeout/fail indicator mirrored to bit 5 |
| status_o | output | 8 | Status byte: bit 6 toggle, bit 5 fail |
| array_mode_o | output | 1 | 1 when reads return array data |

## Verification
The hardest state to reach is a program issued while an erase is suspended, because it needs three commands in order, and its completion must land in suspend rather than idle. The bench starts an erase, suspends it, starts a program, and then checks toggling, freezing and resumption read by read. The protected-target timeouts are checked at the exact cycle before and after expiry, with a done pulse injected in between to show that it is ignored.

// File: rtl/tgl_status_pkg.sv
package tgl_status_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PGM,
    ST_ERS,
    ST_PROT,
    ST_SUSP,
    ST_SPGM
  } op_state_e;

  localparam int unsigned TGL_BIT  = 6;
  localparam int unsigned FAIL_BIT = 5;
endpackage

// File: rtl/tgl_timer.sv
module tgl_timer #(
  parameter int unsigned ERS_TMO_CYC = 10000,
  parameter int unsigned PGM_TMO_CYC = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic load_ers_i,
  output logic expired_o
);
  localparam int unsigned MAX_TMO = (ERS_TMO_CYC > PGM_TMO_CYC) ? ERS_TMO_CYC : PGM_TMO_CYC;
  localparam int unsigned CW      = $clog2(MAX_TMO + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_ers_i ? CW'(ERS_TMO_CYC - 1) : CW'(PGM_TMO_CYC - 1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  p_count_down_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/tgl_ctrl.sv
module tgl_ctrl
  import tgl_status_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_pgm_i,
  input  logic start_ers_i,
  input  logic prot_i,
  input  logic susp_i,
  input  logic resume_i,
  input  logic done_i,
  input  logic expired_i,
  output logic load_o,
  output logic load_ers_o,
  output logic busy_o,
  output logic array_o
);
  op_state_e state_q, state_d;
  logic      ret_susp_q;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_ers_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ers_i) begin
          if (prot_i) begin
            state_d    = ST_PROT;
            load_o     = 1'b1;
            load_ers_o = 1'b1;
          end else begin
            state_d = ST_ERS;
          end
        end else if (start_pgm_i) begin
          if (prot_i) begin
            state_d = ST_PROT;
            load_o  = 1'b1;
          end else begin
            state_d = ST_PGM;
          end
        end
      end
      ST_PGM:  if (done_i) state_d = ST_IDLE;
      ST_ERS: begin
        if (done_i)      state_d = ST_IDLE;
        else if (susp_i) state_d = ST_SUSP;
      end
      ST_PROT: if (expired_i) state_d = ret_susp_q ? ST_SUSP : ST_IDLE;
      ST_SUSP: begin
        if (resume_i) begin
          state_d = ST_ERS;
        end else if (start_pgm_i) begin
          if (prot_i) begin
            state_d = ST_PROT;
            load_o  = 1'b1;
          end else begin
            state_d = ST_SPGM;
          end
        end
      end
      ST_SPGM: if (done_i) state_d = ST_SUSP;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ret_susp_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_o) ret_susp_q <= (state_q == ST_SUSP);
    end
  end

  assign busy_o  = (state_q == ST_PGM) || (state_q == ST_ERS) ||
                   (state_q == ST_PROT) || (state_q == ST_SPGM);
  assign array_o = (state_q == ST_IDLE);

  p_done_ends_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_PGM || state_q == ST_ERS) && done_i) |=> array_o);
  p_prot_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PROT && !expired_i) |=> state_q == ST_PROT);
  p_susp_stay_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SUSP && !resume_i && !start_pgm_i) |=> (state_q == ST_SUSP && !busy_o));
  p_spgm_back_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SPGM && done_i) |=> state_q == ST_SUSP);
  p_ers_first_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_ers_i && start_pgm_i && !prot_i) |=> state_q == ST_ERS);
endmodule

// File: rtl/tgl_flop.sv
module tgl_flop
  import tgl_status_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_i,
  input  logic       busy_i,
  input  logic       fail_i,
  output logic [7:0] status_o
);
  logic tgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              tgl_q <= 1'b0;
    else if (busy_i && rd_i)  tgl_q <= ~tgl_q;
  end

  always_comb begin
    status_o           = '0;
    status_o[TGL_BIT]  = tgl_q;
    status_o[FAIL_BIT] = fail_i;
  end

  p_flip_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && rd_i) |=> tgl_q != $past(tgl_q));
  p_freeze_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> $stable(tgl_q));
endmodule

// File: rtl/tgl_status_top.sv
module tgl_status_top #(
  parameter int unsigned ERS_TMO_CYC = 10000,
  parameter int unsigned PGM_TMO_CYC = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_i,
  input  logic       start_pgm_i,
  input  logic       start_ers_i,
  input  logic       prot_i,
  input  logic       susp_i,
  input  logic       resume_i,
  input  logic       done_i,
  input  logic       fail_i,
  output logic [7:0] status_o,
  output logic       array_mode_o
);
  logic load, load_ers, expired, busy;

  tgl_timer #(
    .ERS_TMO_CYC(ERS_TMO_CYC),
    .PGM_TMO_CYC(PGM_TMO_CYC)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_ers_i (load_ers),
    .expired_o  (expired)
  );

  tgl_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_pgm_i (start_pgm_i),
    .start_ers_i (start_ers_i),
    .prot_i      (prot_i),
    .susp_i      (susp_i),
    .resume_i    (resume_i),
    .done_i      (done_i),
    .expired_i   (expired),
    .load_o      (load),
    .load_ers_o  (load_ers),
    .busy_o      (busy),
    .array_o     (array_mode_o)
  );

  tgl_flop u_flop (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (rd_i),
    .busy_i   (busy),
    .fail_i   (fail_i),
    .status_o (status_o)
  );

  p_fixed_bits_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[7] == 1'b0) && (status_o[4:0] == 5'd0));
  p_array_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (array_mode_o && rd_i) |=> $stable(status_o[6]));
endmodule

// File: tb/sim_tgl_status_top.sv
module sim_tgl_status_top;
  localparam int unsigned ETMO = 20;
  localparam int unsigned PTMO = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd = 0, spgm = 0, sers = 0, prot = 0, susp = 0, resm = 0, done = 0, fail = 0;
  logic [7:0] status;
  logic array_mode;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tgl_status_top #(.ERS_TMO_CYC(ETMO), .PGM_TMO_CYC(PTMO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .start_pgm_i(spgm), .start_ers_i(sers),
    .prot_i(prot), .susp_i(susp), .resume_i(resm), .done_i(done), .fail_i(fail),
    .status_o(status), .array_mode_o(array_mode)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one read cycle; flip says whether bit 6 must invert
  task automatic rd_chk(string req, bit flip);
    logic b;
    b = status[6];
    rd = 1; tick(); rd = 0;
    chk(req, {7'd0, status[6]}, {7'd0, flip ? ~b : b});
  endtask

  task automatic t_reset();
    chk("R1 status", status, 8'h00);
    chk("R1 array", {7'd0, array_mode}, 8'd1);
  endtask

  task automatic t_program();
    prot = 0; spgm = 1; tick(); spgm = 0;
    chk("R9 busy after start", {7'd0, array_mode}, 8'd0);
    rd_chk("R9 first read toggles", 1);
    rd_chk("R2 second read", 1);
    rd_chk("R2 third read", 1);
    sers = 1; tick(); sers = 0;
    susp = 1; tick(); susp = 0;
    chk("R10 susp ignored in program", {7'd0, array_mode}, 8'd0);
    rd_chk("R10 still toggling", 1);
    done = 1; tick(); done = 0;
    chk("R3 array after done", {7'd0, array_mode}, 8'd1);
    rd_chk("R3 frozen after done", 0);
    rd_chk("R3 frozen again", 0);
  endtask

  task automatic t_fail_bits();
    fail = 1; tick();
    chk("R8 fail bit", status & 8'hBF, 8'h20);
    fail = 0; tick();
    chk("R8 fail clear", status & 8'hBF, 8'h00);
  endtask

  task automatic t_prot(string req, bit ers, int unsigned tmo);
    prot = 1;
    if (ers) sers = 1; else spgm = 1;
    tick(); sers = 0; spgm = 0; prot = 0;
    rd_chk({req, " toggles"}, 1);
    done = 1; tick(); done = 0;
    for (int i = 2; i < tmo - 1; i++) tick();
    chk({req, " busy at last cycle"}, {7'd0, array_mode}, 8'd0);
    tick();
    chk({req, " array after timeout"}, {7'd0, array_mode}, 8'd1);
    rd_chk({req, " frozen"}, 0);
  endtask

  task automatic t_suspend();
    prot = 0; sers = 1; tick(); sers = 0;
    rd_chk("R6 erase toggles", 1);
    susp = 1; tick(); susp = 0;
    rd_chk("R6 frozen in suspend", 0);
    chk("R6 not array in suspend", {7'd0, array_mode}, 8'd0);
    spgm = 1; tick(); spgm = 0;
    rd_chk("R7 suspend program toggles", 1);
    rd_chk("R7 suspend program toggles again", 1);
    done = 1; tick(); done = 0;
    chk("R7 back to suspend not array", {7'd0, array_mode}, 8'd0);
    rd_chk("R7 frozen after program", 0);
    resm = 1; tick(); resm = 0;
    rd_chk("R6 toggles after resume", 1);
    done = 1; tick(); done = 0;
    chk("R3 erase done", {7'd0, array_mode}, 8'd1);
  endtask

  task automatic t_priority();
    // both starts, protected: must take the long erase timeout
    prot = 1; sers = 1; spgm = 1; tick(); sers = 0; spgm = 0; prot = 0;
    for (int i = 0; i < int'(PTMO) + 2; i++) tick();
    chk("R10 erase wins", {7'd0, array_mode}, 8'd0);
    for (int i = int'(PTMO) + 2; i < int'(ETMO); i++) tick();
    chk("R10 erase timeout over", {7'd0, array_mode}, 8'd1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    t_reset();
    rst_n = 1; tick();
    t_reset();
    t_program();
    t_fail_bits();
    t_prot("R4", 1, ETMO);
    t_prot("R5", 0, PTMO);
    t_suspend();
    t_priority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule